// File: doc/BRIEF.md
# SMI Event Routing Controller

This block gathers a wide set of event inputs and steers each one to one of three interrupt outputs: a system management interrupt, a non-maskable interrupt or the legacy coprocessor-error interrupt line. A rising edge on any event input latches a status bit. That status bit stays set until software clears it by writing a one to it. Each source has a 2-bit routing field that decides which output the latched bit feeds, or whether it feeds none.

The status bits sit in six 32-bit groups. A 16-bit summary word shows which groups hold a pending bit, so a handler can skip the groups that are empty. SMI assertion is guarded by an end-of-SMI handshake bit. The hardware clears that bit when it fires an SMI, and the handler sets it again as its final step. Software reaches every register through a plain 32-bit register bus. Writes take effect on the clock edge, and reads return combinationally.

Top module: `smi_event_router`

## Requirements
- R1: After reset all status and routing bits are 0, the trigger word at 0x98 reads 0x8000_0000 (global disable set, end-of-SMI clear), and all three interrupt outputs are low.
- R2: A status bit is set on the cycle after its event input goes from 0 to 1, whatever its routing mode. A status bit is never lost without a bus write. An input held high does not set the bit again once software has cleared it.
- R3: Source n lands in status group n/32 at bit n%32. The group offsets are, in order, 0x80 (group 0), 0x84, 0x88, 0x8C, 0x90 and 0x10 (group 5).
- R4: A write to a status group clears exactly the bits written as 1. Bits written as 0 are unchanged, so writing back the value just read empties the group.
- R5: When a rising edge and a clearing write hit the same status bit in one cycle, the bit ends up set.
- R6: The summary word at 0x94 has bit 0 set for group 0x10, bit 1 for 0x80, bit 2 for 0x84, bit 3 for 0x88, bit 4 for 0x8C and bit 5 for 0x90. Each bit is 1 while its group is non-zero, and all other bits read 0.
- R7: The routing word for source n is at 0xA0 + 4*(n/16), bits [2*(n%16) +: 2]. The codes are 0 = none, 1 = SMI, 2 = NMI and 3 = IRQ13. Routing words read back as written.
- R8: `nmi_level` is high exactly while some set status bit has code 2. `irq13_level` is high exactly while some set status bit has code 3.
- R9: `smi_pulse` is high for one cycle when end-of-SMI (bit 28 of 0x98) is 1, the disable bit (bit 31 of 0x98) is 0, and some set status bit has code 1. End-of-SMI then reads 0. A write to 0x98 in that same cycle cannot keep it set.
- R10: No SMI fires while end-of-SMI is 0 or the disable bit is 1, even with SMI-routed bits pending.
- R11: Addresses outside the map read 0, and writes to them change nothing. Bits of 0x98 other than 31 and 28 read 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_wr | input | 1 | Write strobe for the register bus |
| bus_addr | input | 8 | Byte offset of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr`, combinational |
| evt_in | input | NUM_SRC | Event inputs, edge detected |
| smi_pulse | output | 1 | One-cycle system management interrupt |
| nmi_level | output | 1 | Non-maskable interrupt request level |
| irq13_level | output | 1 | Legacy interrupt 13 request level |

## Verification
The bench builds the block with its default NUM_SRC of 150. That value places sources in every populated group, including the partly filled group at 0x90 that holds source 149. It also leaves group 0x10 empty, which shows that unpopulated status bits read 0. With 150 sources the routing words run to 0xC4, so the last word is only partly used. The bench also covers the SMI handshake cycle by cycle: an SMI that is held off by the disable bit, then by a cleared end-of-SMI bit, and then fires again once the bit is set once more.

// File: rtl/smi_event_router.sv
`timescale 1ns/1ps
module smi_event_router #(
  parameter int          NUM_SRC  = 150,
  parameter logic [7:0]  TRIG_OFF = 8'h98,
  parameter logic [7:0]  SUM_OFF  = 8'h94,
  parameter logic [7:0]  CTL_BASE = 8'hA0,
  parameter int          EOS_BIT  = 28,
  parameter int          DIS_BIT  = 31
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               bus_wr,
  input  logic [7:0]         bus_addr,
  input  logic [31:0]        bus_wdata,
  output logic [31:0]        bus_rdata,
  input  logic [NUM_SRC-1:0] evt_in,
  output logic               smi_pulse,
  output logic               nmi_level,
  output logic               irq13_level
);
  localparam int NGRP  = 6;
  localparam int ST_W  = NGRP * 32;
  localparam int NCTL  = (NUM_SRC + 15) / 16;
  localparam int CTL_W = NCTL * 32;

  function automatic logic [7:0] grp_off(input int k);
    case (k)
      0: return 8'h80;
      1: return 8'h84;
      2: return 8'h88;
      3: return 8'h8C;
      4: return 8'h90;
      default: return 8'h10;
    endcase
  endfunction

  logic [NUM_SRC-1:0] evt_q, rise, st_q, st_clr;
  logic [NUM_SRC-1:0] smi_sel, nmi_sel, irq_sel;
  logic [ST_W-1:0]    st_full;
  logic [CTL_W-1:0]   ctl_q;
  logic [15:0]        sum_v;
  logic               eos_q, dis_q, smi_fire, trig_wr;

  assign rise     = evt_in & ~evt_q;
  assign st_full  = ST_W'(st_q);
  assign trig_wr  = bus_wr && (bus_addr == TRIG_OFF);

  always_comb begin
    for (int i = 0; i < NUM_SRC; i++)
      st_clr[i] = bus_wr && (bus_addr == grp_off(i / 32)) && bus_wdata[i % 32];
  end

  for (genvar g = 0; g < NUM_SRC; g++) begin : g_route
    assign smi_sel[g] = st_q[g] && (ctl_q[2*g +: 2] == 2'd1);
    assign nmi_sel[g] = st_q[g] && (ctl_q[2*g +: 2] == 2'd2);
    assign irq_sel[g] = st_q[g] && (ctl_q[2*g +: 2] == 2'd3);
  end

  assign smi_fire    = eos_q && !dis_q && (|smi_sel);
  assign smi_pulse   = smi_fire;
  assign nmi_level   = |nmi_sel;
  assign irq13_level = |irq_sel;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      evt_q <= '0;
      st_q  <= '0;
      ctl_q <= '0;
      eos_q <= 1'b0;
      dis_q <= 1'b1;
    end else begin
      evt_q <= evt_in;
      st_q  <= (st_q & ~st_clr) | rise;
      if (trig_wr) dis_q <= bus_wdata[DIS_BIT];
      if (smi_fire)     eos_q <= 1'b0;
      else if (trig_wr) eos_q <= bus_wdata[EOS_BIT];
      for (int c = 0; c < NCTL; c++)
        if (bus_wr && (bus_addr == CTL_BASE + 8'(4 * c)))
          ctl_q[c*32 +: 32] <= bus_wdata;
    end
  end

  always_comb begin
    sum_v = '0;
    for (int k = 0; k < NGRP; k++)
      sum_v[(k + 1) % NGRP] = |st_full[k*32 +: 32];
  end

  always_comb begin
    bus_rdata = '0;
    if (bus_addr == TRIG_OFF) begin
      bus_rdata[DIS_BIT] = dis_q;
      bus_rdata[EOS_BIT] = eos_q;
    end
    if (bus_addr == SUM_OFF) bus_rdata = {16'h0, sum_v};
    for (int k = 0; k < NGRP; k++)
      if (bus_addr == grp_off(k)) bus_rdata = st_full[k*32 +: 32];
    for (int c = 0; c < NCTL; c++)
      if (bus_addr == CTL_BASE + 8'(4 * c)) bus_rdata = ctl_q[c*32 +: 32];
  end
endmodule

// File: rtl/smi_event_router_chk.sv
`timescale 1ns/1ps
module smi_event_router_chk #(
  parameter int         NSRC     = 150,
  parameter logic [7:0] TRIG_OFF = 8'h98
) (
  input logic            clk,
  input logic            rst_n,
  input logic            bus_wr,
  input logic [7:0]      bus_addr,
  input logic            smi_pulse,
  input logic            nmi_level,
  input logic            irq13_level,
  input logic            eos_q,
  input logic [NSRC-1:0] st_q
);
  assert_smi_single_R9: assert property (@(posedge clk) disable iff (!rst_n)
    smi_pulse |=> !smi_pulse);

  assert_eos_cleared_R9: assert property (@(posedge clk) disable iff (!rst_n)
    smi_pulse |=> !eos_q);

  assert_smi_gated_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (!eos_q && !(bus_wr && bus_addr == TRIG_OFF)) |=> !smi_pulse);

  assert_quiet_outputs_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == '0) |-> (!nmi_level && !irq13_level && !smi_pulse));

  assert_status_sticky_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_wr |=> ((st_q & $past(st_q)) == $past(st_q)));
endmodule

bind smi_event_router smi_event_router_chk #(.NSRC(NUM_SRC), .TRIG_OFF(TRIG_OFF)) u_chk (
  .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
  .smi_pulse(smi_pulse), .nmi_level(nmi_level), .irq13_level(irq13_level),
  .eos_q(eos_q), .st_q(st_q)
);

// File: tb/tb_smi_event_router.sv
`timescale 1ns/1ps
module tb_smi_event_router;
  localparam int NS   = 150;
  localparam int NCTL = (NS + 15) / 16;

  logic clk = 0, rst_n = 0, wr = 0;
  logic [7:0] addr = 0;
  logic [31:0] wd = 0, rdata;
  logic [NS-1:0] evt = '0;
  logic smi, nmi, irq;
  int nchk = 0, nerr = 0;
  bit done = 0;

  always #2 clk = ~clk;

  smi_event_router #(.NUM_SRC(NS)) dut (
    .clk(clk), .rst_n(rst_n), .bus_wr(wr), .bus_addr(addr), .bus_wdata(wd),
    .bus_rdata(rdata), .evt_in(evt), .smi_pulse(smi), .nmi_level(nmi), .irq13_level(irq));

  bit mstat[NS];
  bit mprev[NS];
  logic [31:0] mctl[NCTL];
  bit meos, mdis;

  function automatic logic [7:0] goff(int k);
    logic [7:0] t[6] = '{8'h80, 8'h84, 8'h88, 8'h8C, 8'h90, 8'h10};
    return t[k];
  endfunction

  function automatic int mmode(int i);
    return int'(mctl[i/16][(i%16)*2 +: 2]);
  endfunction

  function automatic bit m_route(int code);
    for (int i = 0; i < NS; i++) if (mstat[i] && mmode(i) == code) return 1;
    return 0;
  endfunction

  function automatic bit m_smi();
    return meos && !mdis && m_route(1);
  endfunction

  function automatic logic [31:0] exp_rd(logic [7:0] a);
    logic [31:0] r = '0;
    if (a == 8'h98) begin r[31] = mdis; r[28] = meos; end
    if (a == 8'h94)
      for (int k = 0; k < 6; k++)
        for (int b = 0; b < 32; b++)
          if (k*32 + b < NS && mstat[k*32 + b]) r[(k + 1) % 6] = 1'b1;
    for (int k = 0; k < 6; k++)
      if (a == goff(k))
        for (int b = 0; b < 32; b++)
          if (k*32 + b < NS) r[b] = mstat[k*32 + b];
    for (int c = 0; c < NCTL; c++)
      if (a == 8'hA0 + 8'(4*c)) r = mctl[c];
    return r;
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < NS; i++) begin mstat[i] = 0; mprev[i] = 0; end
      for (int c = 0; c < NCTL; c++) mctl[c] = '0;
      meos = 0; mdis = 1;
    end else begin
      automatic bit fire = m_smi();
      if (wr) begin
        if (addr == 8'h98) begin mdis = wd[31]; meos = wd[28]; end
        for (int k = 0; k < 6; k++)
          if (addr == goff(k))
            for (int b = 0; b < 32; b++)
              if (k*32 + b < NS && wd[b]) mstat[k*32 + b] = 0;
        for (int c = 0; c < NCTL; c++)
          if (addr == 8'hA0 + 8'(4*c)) mctl[c] = wd;
      end
      if (fire) meos = 0;
      for (int i = 0; i < NS; i++) begin
        if (evt[i] && !mprev[i]) mstat[i] = 1;
        mprev[i] = evt[i];
      end
    end
  end

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nerr++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  always @(negedge clk) if (rst_n && !done) begin
    chk("R9 smi_pulse vs model", 32'(smi), 32'(m_smi()));
    chk("R8 nmi_level vs model", 32'(nmi), 32'(m_route(2)));
    chk("R8 irq13_level vs model", 32'(irq), 32'(m_route(3)));
  end

  task automatic wreg(logic [7:0] a, logic [31:0] d);
    @(negedge clk); wr = 1; addr = a; wd = d;
    @(negedge clk); wr = 0;
  endtask

  task automatic rchk(logic [7:0] a, string tag);
    @(negedge clk); wr = 0; addr = a; #1;
    chk(tag, rdata, exp_rd(a));
  endtask

  task automatic rlit(logic [7:0] a, logic [31:0] e, string tag);
    @(negedge clk); wr = 0; addr = a; #1;
    chk(tag, rdata, e);
  endtask

  task automatic pulse(int i);
    @(negedge clk); evt[i] = 1;
    @(negedge clk); evt[i] = 0;
  endtask

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    idle(3);
    rst_n = 1;
    rlit(8'h98, 32'h8000_0000, "R1 trigger reset value");
    rlit(8'hA0, 32'h0, "R1 routing reset value");
    rlit(8'h94, 32'h0, "R1 summary reset value");
    chk("R1 outputs low after reset", {29'h0, smi, nmi, irq}, 32'h0);

    wreg(8'hA0, 32'h0000_0040);
    wreg(8'hA8, 32'h0002_0000);
    wreg(8'hC4, 32'h0000_0C00);
    rlit(8'hA8, 32'h0002_0000, "R7 routing readback src40 code2");
    rlit(8'hC4, 32'h0000_0C00, "R7 routing readback src149 code3");
    rchk(8'hA0, "R7 routing readback src3 code1");

    pulse(5);
    idle(1);
    rlit(8'h80, 32'h0000_0020, "R2 mode-0 source latches");
    rlit(8'h94, 32'h0000_0002, "R6 summary bit1 for group 0x80");
    @(negedge clk); evt[70] = 1;
    idle(2);
    rlit(8'h88, 32'h0000_0040, "R3 src70 in group 0x88 bit6");
    rlit(8'h94, 32'h0000_000A, "R6 summary bits1 and 3");
    wreg(8'h88, 32'h0000_0040);
    idle(2);
    rlit(8'h88, 32'h0, "R2 held level does not relatch");
    rlit(8'h94, 32'h0000_0002, "R4 summary after clear");
    @(negedge clk); evt[70] = 0;

    pulse(40);
    idle(1);
    rlit(8'h84, 32'h0000_0100, "R3 src40 in group 0x84 bit8");
    chk("R8 nmi high for code2", 32'(nmi), 32'h1);
    pulse(149);
    idle(1);
    rlit(8'h90, 32'h0020_0000, "R3 src149 in group 0x90 bit21");
    rlit(8'h94, 32'h0000_0026, "R6 summary bits1,2,5");
    rlit(8'h10, 32'h0, "R3 group 0x10 empty at 150 sources");
    chk("R8 irq13 high for code3", 32'(irq), 32'h1);
    wreg(8'h84, 32'hFFFF_FEFF);
    rlit(8'h84, 32'h0000_0100, "R4 zero bits leave status");
    wreg(8'h84, 32'h0000_0100);
    wreg(8'h90, 32'h0020_0000);
    idle(1);
    chk("R8 nmi low after clear", 32'(nmi), 32'h0);
    chk("R8 irq13 low after clear", 32'(irq), 32'h0);

    pulse(3);
    idle(2);
    chk("R10 no smi while disabled", 32'(smi), 32'h0);
    wreg(8'h98, 32'h1000_0000);
    idle(2);
    rlit(8'h98, 32'h0, "R9 end-of-SMI cleared by hardware");
    idle(3);
    wreg(8'h98, 32'h9000_0000);
    idle(2);
    rlit(8'h98, 32'h9000_0000, "R10 end-of-SMI held while disabled");
    rchk(8'h80, "R4 readback before write-back");
    wreg(8'h80, exp_rd(8'h80));
    rlit(8'h80, 32'h0, "R4 write-back empties group");
    wreg(8'h98, 32'h1000_0000);
    idle(2);
    rlit(8'h98, 32'h1000_0000, "R10 no pending keeps end-of-SMI");
    pulse(3);
    idle(2);
    rlit(8'h98, 32'h0, "R9 second smi after re-arm");

    pulse(7);
    pulse(5);
    @(negedge clk); evt[7] = 1; wr = 1; addr = 8'h80; wd = 32'h0000_00A0;
    @(negedge clk); wr = 0; evt[7] = 0;
    rlit(8'h80, 32'h0000_0088, "R5 new edge beats clear");

    rlit(8'h00, 32'h0, "R11 unmapped read");
    wreg(8'h20, 32'hFFFF_FFFF);
    rlit(8'h20, 32'h0, "R11 unmapped write ignored");
    rchk(8'hA0, "R11 routing untouched by stray write");
    wreg(8'h98, 32'h0FFF_FFFF);
    rlit(8'h98, 32'h0000_0000, "R11 reserved trigger bits read 0");
    idle(4);

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
    $finish;
  end

  initial begin
    #400000;
    if (!done) begin
      done = 1;
      nchk++; nerr++;
      $display("FAIL watchdog actual=running expected=done");
      $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
      $finish;
    end
  end
endmodule